// File: doc/BRIEF.md
# Self-Starting Five-State Sequence Counter

This block is a 3-bit synchronous counter whose states follow a fixed cycle that is not in numeric order. The cycle is 2, 3, 5, 1, 7 and then 2 again, so the counter is modulo 5. All three state bits update on the same clock edge. The counter advances only on edges where the count enable is high. When the enable is low, the state holds.

The three codes that are not in the cycle are 0, 4 and 6. Each of them goes straight to the entry state 2 on the next enabled edge. This lets the counter recover from any upset state, so it is self-starting. A synchronous reset loads the entry state. A terminal flag is high while the state is 7, the last state before the wrap to 2.

The cycle, the width, the recovery target and the reset value are parameters. They are checked during elaboration. A parameter also chooses how the next-state function is built: as a chain of comparisons or as a table covering every code.

Top module: `seq5_counter`

## Requirements
- R1: On a clock edge with `rst` high, `state_q` becomes the reset code. The default reset code is 2.
- R2: On a clock edge with `rst` low and `cnt_en` high, a state in the cycle moves to its successor: 2 to 3, 3 to 5, 5 to 1, 1 to 7, and 7 back to 2.
- R3: On a clock edge with `rst` low and `cnt_en` high, the codes outside the cycle (0, 4 and 6) move to 2.
- R4: On a clock edge with `rst` low and `cnt_en` low, `state_q` keeps its value. This includes codes outside the cycle.
- R5: `at_last` is 1 exactly when `state_q` is 7, and 0 for every other code. While counting is enabled, it lasts one cycle.
- R6: `rst` takes priority over `cnt_en`. An edge with both high loads the reset code.
- R7: After any enabled edge without reset, `state_q` is one of 1, 2, 3, 5 or 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Count enable, active high |
| state_q | output | 3 | Present state code |
| at_last | output | 1 | High while the state is the last one of the cycle (7) |

## Verification
The checker verifies on every cycle that each cycle state moves to its successor and that unused codes fall to 2. It also checks that a disabled edge leaves the state unchanged, that reset wins over enable, and that the terminal flag matches state 7. The bench's scenarios are needed for the things a property cannot see in a default instance. These are reaching the unused codes at all, which the bench does with extra instances whose reset code is 0, 4 or 6. They also include showing that the table-built and comparison-built variants walk the same cycle order.

// File: rtl/seqctr_pkg.sv
package seqctr_pkg;

   localparam int DEF_W   = 3;
   localparam int DEF_LEN = 5;

   // Cycle order: index 0 is the entry state, index LEN-1 the last before wrap.
   localparam logic [DEF_LEN-1:0][DEF_W-1:0] DEF_SEQ =
      {3'd7, 3'd1, 3'd5, 3'd3, 3'd2};

   localparam logic [DEF_W-1:0] DEF_ENTRY = 3'd2;

   typedef enum int {
      NEXT_CHAIN = 0,
      NEXT_TABLE = 1
   } next_impl_e;

endpackage

// File: rtl/seqctr_next.sv
module seqctr_next
   import seqctr_pkg::*;
#(
   parameter int W = DEF_W,
   parameter int LEN = DEF_LEN,
   parameter logic [LEN-1:0][W-1:0] SEQ = DEF_SEQ,
   parameter logic [W-1:0] RECOVER_CODE = DEF_ENTRY,
   parameter int NEXT_IMPL = NEXT_CHAIN
)(
   input  logic [W-1:0] cur,
   output logic [W-1:0] nxt
);

   localparam int CODES = 1 << W;

   typedef logic [CODES-1:0][W-1:0] lut_t;

   function automatic lut_t build_lut();
      lut_t t;
      for (int c = 0; c < CODES; c++) begin
         t[c] = RECOVER_CODE;
         for (int i = 0; i < LEN; i++) begin
            if (SEQ[i] == c[W-1:0]) begin
               t[c] = SEQ[(i + 1) % LEN];
            end
         end
      end
      return t;
   endfunction

   generate
      if (NEXT_IMPL == NEXT_TABLE) begin : g_table
         localparam lut_t LUT = build_lut();
         assign nxt = LUT[cur];
      end else begin : g_chain
         always_comb begin
            nxt = RECOVER_CODE;
            for (int i = 0; i < LEN; i++) begin
               if (cur == SEQ[i]) begin
                  nxt = SEQ[(i + 1) % LEN];
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/seqctr_reg.sv
module seqctr_reg
   import seqctr_pkg::*;
#(
   parameter int W = DEF_W,
   parameter logic [W-1:0] RESET_CODE = DEF_ENTRY
)(
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         q <= RESET_CODE;
      end else if (en) begin
         q <= d;
      end
   end

endmodule

// File: rtl/seqctr_last.sv
module seqctr_last
   import seqctr_pkg::*;
#(
   parameter int W = DEF_W,
   parameter logic [W-1:0] LAST_CODE = 3'd7
)(
   input  logic [W-1:0] q,
   output logic         last
);

   assign last = (q == LAST_CODE);

endmodule

// File: rtl/seq5_counter.sv
module seq5_counter
   import seqctr_pkg::*;
#(
   parameter int W = DEF_W,
   parameter int LEN = DEF_LEN,
   parameter logic [LEN-1:0][W-1:0] SEQ = DEF_SEQ,
   parameter logic [W-1:0] RECOVER_CODE = DEF_ENTRY,
   parameter logic [W-1:0] RESET_CODE = DEF_ENTRY,
   parameter int NEXT_IMPL = NEXT_CHAIN
)(
   input  logic         clk,
   input  logic         rst,
   input  logic         cnt_en,
   output logic [W-1:0] state_q,
   output logic         at_last
);

   localparam int CODES = 1 << W;
   localparam logic [W-1:0] LAST_CODE = SEQ[LEN-1];

   function automatic int count_dups();
      int n = 0;
      for (int i = 0; i < LEN; i++) begin
         for (int j = i + 1; j < LEN; j++) begin
            if (SEQ[i] == SEQ[j]) n++;
         end
      end
      return n;
   endfunction

   function automatic bit in_cycle(logic [W-1:0] code);
      bit hit = 1'b0;
      for (int i = 0; i < LEN; i++) begin
         if (SEQ[i] == code) hit = 1'b1;
      end
      return hit;
   endfunction

   generate
      if (W < 1 || W > 8) begin : g_bad_width
         $error("seq5_counter: W must be 1..8");
      end
      if (LEN < 2 || LEN > CODES) begin : g_bad_len
         $error("seq5_counter: LEN must be 2..2**W");
      end
      if (count_dups() != 0) begin : g_bad_dup
         $error("seq5_counter: SEQ holds repeated codes");
      end
      if (!in_cycle(RECOVER_CODE)) begin : g_bad_recover
         $error("seq5_counter: RECOVER_CODE is not in SEQ");
      end
      if (NEXT_IMPL != NEXT_CHAIN && NEXT_IMPL != NEXT_TABLE) begin : g_bad_impl
         $error("seq5_counter: unknown NEXT_IMPL");
      end
   endgenerate

   logic [W-1:0] nxt;

   seqctr_next #(
      .W(W), .LEN(LEN), .SEQ(SEQ),
      .RECOVER_CODE(RECOVER_CODE), .NEXT_IMPL(NEXT_IMPL)
   ) u_next (
      .cur(state_q),
      .nxt(nxt)
   );

   seqctr_reg #(
      .W(W), .RESET_CODE(RESET_CODE)
   ) u_reg (
      .clk(clk),
      .rst(rst),
      .en(cnt_en),
      .d(nxt),
      .q(state_q)
   );

   seqctr_last #(
      .W(W), .LAST_CODE(LAST_CODE)
   ) u_last (
      .q(state_q),
      .last(at_last)
   );

endmodule

// File: rtl/seq5_counter_chk.sv
module seq5_counter_chk
   import seqctr_pkg::*;
#(
   parameter int W = DEF_W,
   parameter int LEN = DEF_LEN,
   parameter logic [LEN-1:0][W-1:0] SEQ = DEF_SEQ,
   parameter logic [W-1:0] RECOVER_CODE = DEF_ENTRY,
   parameter logic [W-1:0] RESET_CODE = DEF_ENTRY
)(
   input logic         clk,
   input logic         rst,
   input logic         cnt_en,
   input logic [W-1:0] state_q,
   input logic         at_last
);

   function automatic bit member(logic [W-1:0] code);
      bit hit = 1'b0;
      for (int i = 0; i < LEN; i++) begin
         if (SEQ[i] == code) hit = 1'b1;
      end
      return hit;
   endfunction

   // R1 R6
   reset_load_chk: assert property (@(posedge clk)
      rst |=> state_q == RESET_CODE);

   generate
      for (genvar i = 0; i < LEN; i++) begin : g_step
         // R2
         cycle_step_chk: assert property (@(posedge clk) disable iff (rst)
            (cnt_en && state_q == SEQ[i]) |=> state_q == SEQ[(i + 1) % LEN]);
      end
   endgenerate

   // R3
   unused_recover_chk: assert property (@(posedge clk) disable iff (rst)
      (cnt_en && !member(state_q)) |=> state_q == RECOVER_CODE);

   // R4
   hold_state_chk: assert property (@(posedge clk) disable iff (rst)
      !cnt_en |=> $stable(state_q));

   // R5
   last_flag_chk: assert property (@(posedge clk)
      at_last == (state_q == SEQ[LEN-1]));

   // R5
   last_single_chk: assert property (@(posedge clk) disable iff (rst)
      (at_last && cnt_en) |=> !at_last);

   // R7
   in_cycle_chk: assert property (@(posedge clk) disable iff (rst)
      cnt_en |=> member(state_q));

endmodule

bind seq5_counter seq5_counter_chk #(
   .W(W), .LEN(LEN), .SEQ(SEQ),
   .RECOVER_CODE(RECOVER_CODE), .RESET_CODE(RESET_CODE)
) chk (
   .clk(clk),
   .rst(rst),
   .cnt_en(cnt_en),
   .state_q(state_q),
   .at_last(at_last)
);

// File: tb/seq5_counter_test.sv
module seq5_counter_test;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic cnt_en = 1'b0;
   logic en_x = 1'b0;

   logic [2:0] st, st_t, st0, st4, st6;
   logic lst, lst_t, lst0, lst4, lst6;

   int n_vec = 0;
   int n_bad = 0;
   int cycles = 0;

   always #10 clk = ~clk;   // 50 MHz

   seq5_counter uut (
      .clk(clk), .rst(rst), .cnt_en(cnt_en), .state_q(st), .at_last(lst));

   seq5_counter #(.NEXT_IMPL(1)) uut_tbl (
      .clk(clk), .rst(rst), .cnt_en(cnt_en), .state_q(st_t), .at_last(lst_t));

   seq5_counter #(.RESET_CODE(3'd0)) u_c0 (
      .clk(clk), .rst(rst), .cnt_en(en_x), .state_q(st0), .at_last(lst0));
   seq5_counter #(.RESET_CODE(3'd4)) u_c4 (
      .clk(clk), .rst(rst), .cnt_en(en_x), .state_q(st4), .at_last(lst4));
   seq5_counter #(.RESET_CODE(3'd6)) u_c6 (
      .clk(clk), .rst(rst), .cnt_en(en_x), .state_q(st6), .at_last(lst6));

   // Vector fields: {rst, cnt_en, expected state[2:0], expected at_last}
   localparam int NV = 16;
   localparam logic [5:0] VEC [NV] = '{
      {1'b1, 1'b0, 3'd2, 1'b0},   // R1 reset loads 2
      {1'b0, 1'b1, 3'd3, 1'b0},   // R2
      {1'b0, 1'b1, 3'd5, 1'b0},   // R2
      {1'b0, 1'b0, 3'd5, 1'b0},   // R4 hold
      {1'b0, 1'b1, 3'd1, 1'b0},   // R2
      {1'b0, 1'b1, 3'd7, 1'b1},   // R5 flag at 7
      {1'b0, 1'b0, 3'd7, 1'b1},   // R4 hold at 7
      {1'b0, 1'b1, 3'd2, 1'b0},   // R2 wrap, R5 flag drops
      {1'b0, 1'b1, 3'd3, 1'b0},   // R7
      {1'b1, 1'b1, 3'd2, 1'b0},   // R6 reset over enable
      {1'b0, 1'b1, 3'd3, 1'b0},   // R2
      {1'b0, 1'b1, 3'd5, 1'b0},   // R2
      {1'b0, 1'b1, 3'd1, 1'b0},   // R2
      {1'b0, 1'b1, 3'd7, 1'b1},   // R5
      {1'b0, 1'b1, 3'd2, 1'b0},   // R2
      {1'b0, 1'b0, 3'd2, 1'b0}    // R4
   };

   task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: state/flag actual %0d/%0d expected %0d/%0d",
                  tag, act[3:1], act[0], exp[3:1], exp[0]);
      end
   endtask

   task automatic step(logic r, logic e, logic ex);
      @(negedge clk);
      rst = r;
      cnt_en = e;
      en_x = ex;
      @(posedge clk);
      #5;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 5000) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
         end
      end
   end

   initial begin
      for (int v = 0; v < NV; v++) begin
         step(VEC[v][5], VEC[v][4], 1'b0);
         chk($sformatf("vector %0d (R1..R7 per table)", v), {st, lst}, VEC[v][3:0]);
         chk($sformatf("vector %0d table variant R2", v), {st_t, lst_t}, VEC[v][3:0]);
      end

      // R1: parameterized reset codes load the unused values
      step(1'b1, 1'b0, 1'b0);
      chk("R1 reset code 0", {st0, lst0}, {3'd0, 1'b0});
      chk("R1 reset code 4", {st4, lst4}, {3'd4, 1'b0});
      chk("R1 reset code 6", {st6, lst6}, {3'd6, 1'b0});

      // R4: unused codes hold while disabled
      step(1'b0, 1'b0, 1'b0);
      chk("R4 hold code 0", {st0, lst0}, {3'd0, 1'b0});
      chk("R4 hold code 4", {st4, lst4}, {3'd4, 1'b0});
      chk("R4 hold code 6", {st6, lst6}, {3'd6, 1'b0});

      // R3: one enabled edge from each unused code reaches 2
      step(1'b0, 1'b0, 1'b1);
      chk("R3 recover from 0", {st0, lst0}, {3'd2, 1'b0});
      chk("R3 recover from 4", {st4, lst4}, {3'd2, 1'b0});
      chk("R3 recover from 6", {st6, lst6}, {3'd2, 1'b0});
      chk("R4 main counter idle", {st, lst}, {3'd2, 1'b0});

      // R7: recovered counters continue in the cycle
      step(1'b0, 1'b0, 1'b1);
      chk("R7 after recovery 0", {st0, lst0}, {3'd3, 1'b0});
      chk("R7 after recovery 6", {st6, lst6}, {3'd3, 1'b0});

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule